// File: doc/BRIEF.md
# Game cartridge command responder

This block answers commands on the card side of a handheld cartridge port. Software reaches it through a control register and a bank of eight command bytes. Writing the control register with its start bit set copies the staged command into the block and decodes the first byte as an opcode. The decode sets a word count and a start address. After that, every read of the data port returns one 32-bit word, steps the address by four and lowers the count. When the count is nonzero the block raises its ready flag and gives a one-cycle DMA request. The DMA engine outside the block can then drain the words without software polling.

ROM words come from a synchronous memory model that is indexed by the address under a parameterised mask. Reads that the secure-read opcode aims at the protected low region are folded into a 512-byte window just above it. One opcode moves the block, one way, into an encrypted-command state. In that state every later start is refused. Only reset leaves that state. The encryption itself is not modelled.

Top module: `cart_cmd_resp`

## Requirements
- R1: A control write with bit 31 clear sets the remaining count and the address to zero. The control value becomes the written word AND 0x7F7FFFFF. A data read that follows returns 0.
- R2: A control write with bit 31 set, made in normal mode, decodes the staged opcode, which is byte index 0 of the command bytes. If the decoded count is nonzero, the control value becomes the written word OR 0x00800000, and `dma_req_o` is high for exactly the one cycle after the write. If the decoded count is zero, the control value becomes the written word AND 0x7F7FFFFF and no DMA request is made. Byte indexes 5 to 7 are accepted but carry no meaning.
- R3: The opcode table gives these counts and word values:
  - 0x9F: 0x800 words, each 0xFFFFFFFF.
  - 0x94: 0x80 words, each 0.
  - 0xD6: 1 word of value 0x80.
  - 0x90 and 0xB8: 1 word of value 0.
  - Any opcode not listed here or in R4 and R8: count 0.
- R4: Opcodes 0x00 and 0xB7 set a count of 0x80. They load the address from byte indexes 1 to 4, with byte 1 as the most significant byte. The ROM model is indexed by word, using address bits [ROM_ABITS-1:2], which is 16:2 by default. The word at index i is (i*0x9E3779B1) XOR 0x5A5AC3C3, taken modulo 2^32.
- R5: For opcode 0xB7 only, an address below 0x8000 is replaced, before the ROM access, by 0x8000 plus the address's bits [8:0]. The next address is the replaced address plus 4. Opcode 0x00 is never remapped.
- R6: `rvalid_o` and `rdata_o` appear in the cycle after `data_re_i`. A read while the count is nonzero advances the address by 4 and lowers the count by one. A read at count 0 returns 0 and changes nothing.
- R7: `ctrl_o` bit 23 is high exactly when the count is nonzero, and bit 31 equals bit 23. The read that takes the count to zero clears bits 31 and 23 at its clock edge. That same read raises `done_o` for one cycle, together with its data.
- R8: Opcode 0x3C sets count 0 and address 0. It clears control bits 31 and 23, and raises `key1_mode_o`.
- R9: Once `key1_mode_o` is high, it stays high until reset. While it is high, a start write behaves as the abort of R1.
- R10: After reset, `ctrl_o` is 0, `key1_mode_o`, `dma_req_o`, `done_o` and `rvalid_o` are low, and a data read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write data |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_idx_i | input | 3 | Command byte index (0 is the opcode) |
| cmd_byte_i | input | 8 | Command byte value |
| data_re_i | input | 1 | Data port read strobe |
| ctrl_o | output | 32 | Control register value |
| rdata_o | output | 32 | Data word, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after data_re_i |
| dma_req_o | output | 1 | One-cycle card DMA request |
| done_o | output | 1 | One-cycle transfer-complete pulse |
| key1_mode_o | output | 1 | Encrypted-command state reached |

## Verification
The assertions assume that a control write and a data read never fall in the same cycle. They also assume that the command bytes are not staged in the same cycle as a start. The stimulus keeps to both rules because it runs one operation per cycle: a byte write, a control write or a read. The random part never issues opcode 0x3C, so the random runs stay in normal mode. The encrypted state, its refusal of starts and the return to normal mode on reset are checked in a directed tail.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int unsigned CMD_KEPT = 5;
  localparam logic [31:0] CTRL_KEEP  = 32'h7F7F_FFFF;
  localparam logic [31:0] CTRL_READY = 32'h0080_0000;
  localparam logic [31:0] PROT_LIMIT = 32'h0000_8000;

  localparam logic [7:0] OP_DUMMY    = 8'h9F;
  localparam logic [7:0] OP_NINIT    = 8'h94;
  localparam logic [7:0] OP_NSTAT    = 8'hD6;
  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_READ_SEC = 8'hB7;
  localparam logic [7:0] OP_ID_A     = 8'h90;
  localparam logic [7:0] OP_ID_B     = 8'hB8;
  localparam logic [7:0] OP_ENC      = 8'h3C;

  typedef enum logic [1:0] {RD_ZERO, RD_ONES, RD_STAT, RD_ROM} rd_kind_e;
  typedef enum logic {MODE_PLAIN, MODE_ENC} card_mode_e;

  function automatic logic [31:0] rom_word(input logic [31:0] idx);
    return (idx * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic rd_kind_e read_kind(input logic [7:0] op);
    case (op)
      OP_DUMMY, OP_ENC:      return RD_ONES;
      OP_NSTAT:              return RD_STAT;
      OP_READ, OP_READ_SEC:  return RD_ROM;
      default:               return RD_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/cart_cmd_latch.sv
module cart_cmd_latch
  import cart_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [7:0]              byte_i,
  input  logic                    capture_i,
  output logic [CMD_KEPT*8-1:0]   stage_o,
  output logic [7:0]              op_o
);
  for (genvar g = 0; g < CMD_KEPT; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                stage_o[g*8 +: 8] <= '0;
      else if (wr_i && idx_i == IDX_W'(g))        stage_o[g*8 +: 8] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        op_o <= '0;
    else if (capture_i) op_o <= stage_o[7:0];
  end
endmodule

// File: rtl/cart_decode.sv
module cart_decode
  import cart_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic [7:0]       op_i,
  input  logic [31:0]      arg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [31:0]      addr_o,
  output logic             enc_o
);
  always_comb begin
    cnt_o  = '0;
    addr_o = '0;
    enc_o  = 1'b0;
    case (op_i)
      OP_DUMMY:              cnt_o = CNT_W'(12'h800);
      OP_NINIT:              cnt_o = CNT_W'(12'h080);
      OP_NSTAT:              cnt_o = CNT_W'(12'h001);
      OP_ID_A, OP_ID_B:      cnt_o = CNT_W'(12'h001);
      OP_READ, OP_READ_SEC: begin
        cnt_o  = CNT_W'(12'h080);
        addr_o = arg_i;
      end
      OP_ENC:                enc_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cart_rom.sv
module cart_rom
  import cart_pkg::*;
#(
  parameter int unsigned IDX_W = 15
) (
  input  logic             clk_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [31:0]      word_o
);
  always_ff @(posedge clk_i) begin
    if (re_i) word_o <= rom_word(32'(idx_i));
  end
endmodule

// File: rtl/cart_cmd_resp.sv
module cart_cmd_resp
  import cart_pkg::*;
#(
  parameter int unsigned ROM_ABITS = 17,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [31:0]      ctrl_wdata_i,
  input  logic             cmd_we_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [7:0]       cmd_byte_i,
  input  logic             data_re_i,
  output logic [31:0]      ctrl_o,
  output logic [31:0]      rdata_o,
  output logic             rvalid_o,
  output logic             dma_req_o,
  output logic             done_o,
  output logic             key1_mode_o
);
  localparam int unsigned WIDX_W = ROM_ABITS - 2;

  logic [CMD_KEPT*8-1:0] stage;
  logic [7:0]            op_q;
  logic [CNT_W-1:0]      cnt_q, dec_cnt;
  logic [31:0]           addr_q, dec_addr, eff_addr, rval_q, rom_q, arg;
  logic                  dec_enc, start, run, rd_fire, remap, sel_rom_q, rom_re;
  card_mode_e            mode_q;
  rd_kind_e              kind;

  assign start = ctrl_we_i && ctrl_wdata_i[31];
  assign run   = start && (mode_q == MODE_PLAIN);
  assign arg   = {stage[15:8], stage[23:16], stage[31:24], stage[39:32]};

  cart_cmd_latch #(.IDX_W(IDX_W)) i_latch (
    .clk_i, .rst_ni,
    .wr_i(cmd_we_i), .idx_i(cmd_idx_i), .byte_i(cmd_byte_i),
    .capture_i(start), .stage_o(stage), .op_o(op_q)
  );

  cart_decode #(.CNT_W(CNT_W)) i_dec (
    .op_i(stage[7:0]), .arg_i(arg),
    .cnt_o(dec_cnt), .addr_o(dec_addr), .enc_o(dec_enc)
  );

  assign kind     = read_kind(op_q);
  assign rd_fire  = data_re_i && !ctrl_we_i && (cnt_q != '0);
  assign remap    = (op_q == OP_READ_SEC) && (addr_q < PROT_LIMIT);
  assign eff_addr = remap ? (PROT_LIMIT + {23'b0, addr_q[8:0]}) : addr_q;
  assign rom_re   = rd_fire && (kind == RD_ROM);

  cart_rom #(.IDX_W(WIDX_W)) i_rom (
    .clk_i, .re_i(rom_re), .idx_i(eff_addr[ROM_ABITS-1:2]), .word_o(rom_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      cnt_q     <= '0;
      addr_q    <= '0;
      mode_q    <= MODE_PLAIN;
      dma_req_o <= 1'b0;
    end else if (ctrl_we_i) begin
      if (run) begin
        cnt_q     <= dec_cnt;
        addr_q    <= dec_addr;
        dma_req_o <= (dec_cnt != '0);
        ctrl_o    <= (dec_cnt != '0) ? (ctrl_wdata_i | CTRL_READY)
                                     : (ctrl_wdata_i & CTRL_KEEP);
        if (dec_enc) mode_q <= MODE_ENC;
      end else begin
        // abort, or start refused in encrypted state
        cnt_q     <= '0;
        addr_q    <= '0;
        dma_req_o <= 1'b0;
        ctrl_o    <= ctrl_wdata_i & CTRL_KEEP;
      end
    end else begin
      dma_req_o <= 1'b0;
      if (rd_fire) begin
        addr_q <= eff_addr + 32'd4;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) ctrl_o <= ctrl_o & CTRL_KEEP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o  <= 1'b0;
      done_o    <= 1'b0;
      sel_rom_q <= 1'b0;
      rval_q    <= '0;
    end else begin
      rvalid_o  <= data_re_i;
      done_o    <= rd_fire && (cnt_q == CNT_W'(1));
      sel_rom_q <= rom_re;
      if (!rd_fire)              rval_q <= '0;
      else case (kind)
        RD_ONES: rval_q <= 32'hFFFF_FFFF;
        RD_STAT: rval_q <= 32'h0000_0080;
        default: rval_q <= '0;
      endcase
    end
  end

  assign rdata_o     = sel_rom_q ? rom_q : rval_q;
  assign key1_mode_o = (mode_q == MODE_ENC);
endmodule

// File: rtl/cart_cmd_resp_chk.sv
module cart_cmd_resp_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic             data_re_i,
  input logic [31:0]      ctrl_o,
  input logic             rvalid_o,
  input logic             dma_req_o,
  input logic             done_o,
  input logic             key1_mode_o,
  input logic [CNT_W-1:0] cnt_q
);
  a_r7_ready_tracks_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[23] == (cnt_q != '0));

  a_r7_start_bit_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[31] == ctrl_o[23]);

  a_r2_dma_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> ($past(ctrl_we_i) && ctrl_o[23]));

  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(data_re_i) && !ctrl_o[23] && cnt_q == '0));

  a_r6_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_re_i |=> rvalid_o);

  a_r9_enc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key1_mode_o |=> key1_mode_o);

  a_r9_enc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key1_mode_o |-> cnt_q == '0);
endmodule

bind cart_cmd_resp cart_cmd_resp_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .data_re_i(data_re_i),
  .ctrl_o(ctrl_o), .rvalid_o(rvalid_o), .dma_req_o(dma_req_o), .done_o(done_o),
  .key1_mode_o(key1_mode_o), .cnt_q(cnt_q)
);

// File: tb/test_cart_cmd_resp.sv
module test_cart_cmd_resp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we = 1'b0, cmd_we = 1'b0, data_re = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [2:0]  cmd_idx = '0;
  logic [7:0]  cmd_byte = '0;
  logic [31:0] ctrl_q, rdata;
  logic        rvalid, dma_req, done, key1;

  always #10 clk = ~clk;

  cart_cmd_resp i_cart_cmd_resp (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .cmd_we_i(cmd_we), .cmd_idx_i(cmd_idx), .cmd_byte_i(cmd_byte),
    .data_re_i(data_re), .ctrl_o(ctrl_q), .rdata_o(rdata), .rvalid_o(rvalid),
    .dma_req_o(dma_req), .done_o(done), .key1_mode_o(key1)
  );

  int total = 0, bad = 0;
  int m_cnt;
  logic [31:0] m_addr, m_ctrl;
  logic [7:0]  m_op;
  logic        m_key1;
  logic [7:0]  m_stage [8];

  function automatic logic [31:0] rom_exp(input logic [31:0] a);
    return (32'(a[16:2]) * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stage_cmd(input logic [7:0] b [8]);
    for (int i = 0; i < 8; i++) begin
      cmd_we = 1'b1; cmd_idx = 3'(i); cmd_byte = b[i];
      m_stage[i] = b[i];
      tick();
    end
    cmd_we = 1'b0;
  endtask

  task automatic ctrl_write(input logic [31:0] w, input string r);
    logic exp_dma;
    exp_dma = 1'b0;
    if (w[31] && !m_key1) begin
      m_op = m_stage[0];
      m_addr = 0;
      case (m_op)
        8'h9F: m_cnt = 'h800;
        8'h94: m_cnt = 'h80;
        8'hD6, 8'h90, 8'hB8: m_cnt = 1;
        8'h00, 8'hB7: begin
          m_cnt = 'h80;
          m_addr = {m_stage[1], m_stage[2], m_stage[3], m_stage[4]};
        end
        8'h3C: begin m_cnt = 0; m_key1 = 1'b1; end
        default: m_cnt = 0;
      endcase
      exp_dma = (m_cnt != 0);
      m_ctrl = exp_dma ? (w | 32'h0080_0000) : (w & 32'h7F7F_FFFF);
    end else begin
      m_cnt = 0; m_addr = 0;
      m_ctrl = w & 32'h7F7F_FFFF;
    end
    ctrl_we = 1'b1; ctrl_wdata = w;
    tick();
    ctrl_we = 1'b0;
    check({r, " ctrl"}, ctrl_q, m_ctrl);
    check({r, " dma"}, 32'(dma_req), 32'(exp_dma));
    check({r, " key1"}, 32'(key1), 32'(m_key1));
  endtask

  task automatic data_read(input string r);
    logic [31:0] exp, a;
    logic exp_done;
    exp = 0; exp_done = 1'b0;
    if (m_cnt != 0) begin
      a = m_addr;
      case (m_op)
        8'h9F: exp = 32'hFFFF_FFFF;
        8'hD6: exp = 32'h80;
        8'h00, 8'hB7: begin
          if (m_op == 8'hB7 && a < 32'h8000) a = 32'h8000 + {23'b0, a[8:0]};
          exp = rom_exp(a);
        end
        default: exp = 0;
      endcase
      m_addr = a + 4;
      m_cnt--;
      if (m_cnt == 0) begin
        exp_done = 1'b1;
        m_ctrl &= 32'h7F7F_FFFF;
      end
    end
    data_re = 1'b1;
    tick();
    data_re = 1'b0;
    check({r, " rvalid"}, 32'(rvalid), 32'd1);
    check({r, " rdata"}, rdata, exp);
    check({r, " done"}, 32'(done), 32'(exp_done));
    check({r, " ctrl"}, ctrl_q, m_ctrl);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_addr = 0; m_ctrl = 0; m_op = 0; m_key1 = 0;
    for (int i = 0; i < 8; i++) m_stage[i] = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b [8];
    logic [7:0] ops [8];
    void'($urandom(32'd20240611));
    ops = '{8'h9F, 8'h94, 8'hD6, 8'h00, 8'hB7, 8'h90, 8'hB8, 8'h55};
    do_reset();
    check("R10 ctrl", ctrl_q, 32'h0);
    check("R10 key1", 32'(key1), 0);
    check("R10 dma/done/rvalid", {29'b0, dma_req, done, rvalid}, 0);
    data_read("R10 read after reset");

    // R3 single-word status and end of transfer
    b = '{8'hD6, 0, 0, 0, 0, 0, 0, 0};
    stage_cmd(b);
    ctrl_write(32'hA1B2_C3D4, "R2 start D6");
    data_read("R3 R7 D6 word");
    data_read("R6 read at count zero");

    // R5 remap against plain read at the same low address
    b = '{8'hB7, 8'h00, 8'h00, 8'h0E, 8'h04, 0, 0, 0};
    stage_cmd(b);
    ctrl_write(32'h8000_0000, "R4 start B7");
    repeat (3) data_read("R5 secure read");
    b[0] = 8'h00;
    stage_cmd(b);
    ctrl_write(32'h8080_0000, "R4 start 00");
    repeat (3) data_read("R4 plain read");

    // R1 abort mid transfer
    ctrl_write(32'h7FFF_FFFF, "R1 abort");
    data_read("R1 read after abort");

    // R3 unknown opcode
    b = '{8'h55, 1, 2, 3, 4, 5, 6, 7};
    stage_cmd(b);
    ctrl_write(32'hFFFF_FFFF, "R3 unknown opcode");

    // random normal-mode traffic
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < 8; i++) b[i] = 8'($urandom());
      b[0] = ops[$urandom_range(0, 7)];
      if ($urandom_range(0, 1) == 0) begin b[1] = 0; b[2] = 0; end
      stage_cmd(b);
      ctrl_write({1'b1, 31'($urandom())}, "R2 R3 random start");
      for (int k = 0; k < int'($urandom_range(0, 6)); k++) data_read("R3 R6 random read");
      if ($urandom_range(0, 3) == 0) ctrl_write({1'b0, 31'($urandom())}, "R1 random abort");
    end

    // drain a whole block read
    b = '{8'h00, 8'h00, 8'h01, 8'hFF, 8'hF0, 0, 0, 0};
    stage_cmd(b);
    ctrl_write(32'h8000_0000, "R4 block start");
    for (int k = 0; k < 'h80; k++) data_read("R7 block drain");
    data_read("R6 read past end");

    // encrypted state
    b = '{8'h3C, 0, 0, 0, 0, 0, 0, 0};
    stage_cmd(b);
    ctrl_write(32'hFFFF_FFFF, "R8 enter encrypted");
    b = '{8'h9F, 0, 0, 0, 0, 0, 0, 0};
    stage_cmd(b);
    ctrl_write(32'h8080_0001, "R9 start refused");
    data_read("R9 read while refused");
    check("R9 still encrypted", 32'(key1), 1);

    do_reset();
    check("R10 mode cleared", 32'(key1), 0);
    check("R10 ctrl cleared", ctrl_q, 0);
    stage_cmd(b);
    ctrl_write(32'h8000_0000, "R10 start after reset");
    data_read("R3 dummy word");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule